// File: doc/BRIEF.md
# Rotating-Parity Array Write Controller

This block sits in front of a five-member striped storage array that keeps one parity block per stripe, with the parity position rotating from stripe to stripe. A host presents logical block reads and writes. The block maps each logical block number to a stripe, a data member and a parity member. It then drives the physical member operations over a per-member request/done port, with at most one operation outstanding on any member.

A logical read costs one physical read on the data member. A logical write is handled as a small read-modify-write. The old data block and the old parity block are read together. The new parity is formed as old parity XOR old data XOR new data. The new data and the new parity are then written back, and the host sees one acknowledge once both writes have completed.

Two request engines let a second request start while the first is still running, provided the two requests need no member in common. A request that would share a member waits with ready low.

Top module: `parity_array_ctrl`

## Requirements
- R1: For a stripe s, the parity member is 4 − (s mod 5), so parity moves one member lower per stripe and wraps after five stripes.
- R2: Logical block n lies in stripe n/4, slot n mod 4. Its data member is the slot if the slot is below the parity member index, otherwise the slot plus one. The data member is never the parity member.
- R3: A logical read issues exactly one physical read, to the data member, and touches no other member. The acknowledge returns the block's stored value on ack_rdata_o.
- R4: A logical write issues one read to the data member and one to the parity member, both at address s. It then issues one write to each of the same members. Neither write is issued before both reads have completed.
- R5: The written parity equals old parity XOR old data XOR new data, so every stripe's parity block stays equal to the XOR of its four data blocks.
- R6: Each accepted request is acknowledged exactly once, with its logical block number and type. A write is acknowledged only after both of its member writes have returned done.
- R7: req_ready_o is high while a request is in flight only if an engine is free and the presented request's member set is disjoint from every in-flight request's member set. A read uses its data member; a write uses its data and parity members.
- R8: No member receives a new operation while its previous operation has not returned done.
- R9: During and right after reset, no member operation and no acknowledge is issued, and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid is high |
| req_write_i | input | 1 | 1 = logical write, 0 = logical read |
| req_lba_i | input | LBA_W | Logical block number |
| req_wdata_i | input | DATA_W | Data for a logical write |
| ack_valid_o | output | 1 | One-cycle completion pulse |
| ack_write_o | output | 1 | Type of the completed request |
| ack_lba_o | output | LBA_W | Block number of the completed request |
| ack_rdata_o | output | DATA_W | Read data of a completed read |
| mem_req_o | output | NUM_MEMBERS | One-cycle operation start, per member |
| mem_we_o | output | NUM_MEMBERS | Operation is a write, per member |
| mem_addr_o | output | NUM_MEMBERS*LBA_W | Stripe address, per member |
| mem_wdata_o | output | NUM_MEMBERS*DATA_W | Write data, per member |
| mem_done_i | input | NUM_MEMBERS | One-cycle completion, per member |
| mem_rdata_i | input | NUM_MEMBERS*DATA_W | Read data valid with done, per member |

## Verification
The bench goes after the mapping corners: a slot at or above the rotated parity index (block 7 on member 4, block 16 on member 1), and stripes where parity sits on member 0 or wraps back to member 4. A wrong offset rule would send reads to the parity member and corrupt the stripe invariant. It also pairs writes to blocks 0 and 5, which need separate members, with writes to blocks 0 and 1, which share parity. A design that stalls the first pair or admits the second would show the wrong ready level, or two operations on one member. Member latencies differ per member and per operation. A controller that issues its writes after only one read, or acknowledges after one write, trips the ordering and count checks and leaves stale parity.

// File: rtl/parity_array_pkg.sv
package parity_array_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_WR_ISSUE,
    ST_WR_WAIT,
    ST_DONE
  } eng_state_e;
endpackage

// File: rtl/parity_array_map.sv
module parity_array_map #(
  parameter int NUM_MEMBERS = 5,
  parameter int LBA_W       = 8,
  localparam int MIDX_W     = $clog2(NUM_MEMBERS)
) (
  input  logic [LBA_W-1:0]       lba_i,
  output logic [LBA_W-1:0]       stripe_o,
  output logic [MIDX_W-1:0]      data_mem_o,
  output logic [MIDX_W-1:0]      par_mem_o,
  output logic [NUM_MEMBERS-1:0] data_mask_o,
  output logic [NUM_MEMBERS-1:0] par_mask_o
);
  localparam int DATA_PER_STRIPE = NUM_MEMBERS - 1;

  logic [LBA_W-1:0] slot_w, rot_w, par_full, dat_full;

  always_comb begin
    stripe_o    = lba_i / LBA_W'(DATA_PER_STRIPE);
    slot_w      = lba_i % LBA_W'(DATA_PER_STRIPE);
    rot_w       = stripe_o % LBA_W'(NUM_MEMBERS);
    par_full    = LBA_W'(NUM_MEMBERS - 1) - rot_w;
    // data skips over the parity member
    dat_full    = (slot_w >= par_full) ? slot_w + LBA_W'(1) : slot_w;
    par_mem_o   = MIDX_W'(par_full);
    data_mem_o  = MIDX_W'(dat_full);
    data_mask_o = NUM_MEMBERS'(1) << data_mem_o;
    par_mask_o  = NUM_MEMBERS'(1) << par_mem_o;
  end
endmodule

// File: rtl/parity_array_engine.sv
module parity_array_engine
  import parity_array_pkg::*;
#(
  parameter int NUM_MEMBERS = 5,
  parameter int DATA_W      = 16,
  parameter int LBA_W       = 8,
  localparam int MIDX_W     = $clog2(NUM_MEMBERS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          write_i,
  input  logic [LBA_W-1:0]              lba_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [LBA_W-1:0]              stripe_i,
  input  logic [MIDX_W-1:0]             data_mem_i,
  input  logic [MIDX_W-1:0]             par_mem_i,
  input  logic [NUM_MEMBERS-1:0]        data_mask_i,
  input  logic [NUM_MEMBERS-1:0]        par_mask_i,
  output logic                          idle_o,
  output logic [NUM_MEMBERS-1:0]        own_o,
  output logic                          done_o,
  input  logic                          grant_i,
  output logic                          ack_write_o,
  output logic [LBA_W-1:0]              ack_lba_o,
  output logic [DATA_W-1:0]             ack_rdata_o,
  output logic [NUM_MEMBERS-1:0]        mem_req_o,
  output logic                          mem_we_o,
  output logic [LBA_W-1:0]              mem_addr_o,
  output logic [NUM_MEMBERS*DATA_W-1:0] mem_wdata_o,
  input  logic [NUM_MEMBERS-1:0]        mem_done_i,
  input  logic [NUM_MEMBERS*DATA_W-1:0] mem_rdata_i
);
  eng_state_e             state_q;
  logic                   is_wr_q, got_d_q, got_p_q;
  logic [LBA_W-1:0]       lba_q, addr_q;
  logic [NUM_MEMBERS-1:0] dmask_q, pmask_q;
  logic [MIDX_W-1:0]      dmem_q, pmem_q;
  logic [DATA_W-1:0]      new_q, old_d_q, old_p_q, new_par;
  logic                   done_d, done_p, d_ok, p_ok;
  logic [DATA_W-1:0]      rd_d, rd_p;

  always_comb begin
    done_d  = mem_done_i[dmem_q];
    done_p  = mem_done_i[pmem_q];
    rd_d    = mem_rdata_i[int'(dmem_q)*DATA_W +: DATA_W];
    rd_p    = mem_rdata_i[int'(pmem_q)*DATA_W +: DATA_W];
    d_ok    = got_d_q | done_d;
    p_ok    = !is_wr_q | got_p_q | done_p;
    new_par = old_p_q ^ old_d_q ^ new_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      got_d_q <= 1'b0;
      got_p_q <= 1'b0;
      lba_q   <= '0;
      addr_q  <= '0;
      dmask_q <= '0;
      pmask_q <= '0;
      dmem_q  <= '0;
      pmem_q  <= '0;
      new_q   <= '0;
      old_d_q <= '0;
      old_p_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          is_wr_q <= write_i;
          lba_q   <= lba_i;
          addr_q  <= stripe_i;
          dmask_q <= data_mask_i;
          pmask_q <= par_mask_i;
          dmem_q  <= data_mem_i;
          pmem_q  <= par_mem_i;
          new_q   <= wdata_i;
          got_d_q <= 1'b0;
          got_p_q <= 1'b0;
          state_q <= ST_RD_ISSUE;
        end
        ST_RD_ISSUE: state_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (done_d) begin
            old_d_q <= rd_d;
            got_d_q <= 1'b1;
          end
          if (is_wr_q && done_p) begin
            old_p_q <= rd_p;
            got_p_q <= 1'b1;
          end
          if (d_ok && p_ok) state_q <= is_wr_q ? ST_WR_ISSUE : ST_DONE;
        end
        ST_WR_ISSUE: begin
          got_d_q <= 1'b0;
          got_p_q <= 1'b0;
          state_q <= ST_WR_WAIT;
        end
        ST_WR_WAIT: begin
          if (done_d) got_d_q <= 1'b1;
          if (done_p) got_p_q <= 1'b1;
          if (d_ok && p_ok) state_q <= ST_DONE;
        end
        ST_DONE: if (grant_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle_o      = (state_q == ST_IDLE);
    own_o       = idle_o ? '0 : (dmask_q | (is_wr_q ? pmask_q : '0));
    done_o      = (state_q == ST_DONE);
    ack_write_o = is_wr_q;
    ack_lba_o   = lba_q;
    ack_rdata_o = old_d_q;
    mem_we_o    = (state_q == ST_WR_ISSUE);
    mem_addr_o  = addr_q;
    mem_req_o   = '0;
    if (state_q == ST_RD_ISSUE || state_q == ST_WR_ISSUE) mem_req_o = own_o;
    for (int m = 0; m < NUM_MEMBERS; m++)
      mem_wdata_o[m*DATA_W +: DATA_W] = dmask_q[m] ? new_q : new_par;
  end

  // R4: writes start only once both old values are held
  p_wr_after_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR_ISSUE) |-> (got_d_q && got_p_q));

  // R3: a logical read drives one member only
  p_read_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ISSUE && !is_wr_q) |-> ($countones(mem_req_o) == 1));

  // R6: a write completes only after both member writes returned
  p_ack_after_writes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_wr_q) |-> (got_d_q && got_p_q));
endmodule

// File: rtl/parity_array_ctrl.sv
module parity_array_ctrl #(
  parameter int NUM_MEMBERS = 5,
  parameter int DATA_W      = 16,
  parameter int LBA_W       = 8,
  parameter int NUM_ENG     = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic                          req_write_i,
  input  logic [LBA_W-1:0]              req_lba_i,
  input  logic [DATA_W-1:0]             req_wdata_i,
  output logic                          ack_valid_o,
  output logic                          ack_write_o,
  output logic [LBA_W-1:0]              ack_lba_o,
  output logic [DATA_W-1:0]             ack_rdata_o,
  output logic [NUM_MEMBERS-1:0]        mem_req_o,
  output logic [NUM_MEMBERS-1:0]        mem_we_o,
  output logic [NUM_MEMBERS*LBA_W-1:0]  mem_addr_o,
  output logic [NUM_MEMBERS*DATA_W-1:0] mem_wdata_o,
  input  logic [NUM_MEMBERS-1:0]        mem_done_i,
  input  logic [NUM_MEMBERS*DATA_W-1:0] mem_rdata_i
);
  localparam int MIDX_W = $clog2(NUM_MEMBERS);

  logic [LBA_W-1:0]       map_stripe;
  logic [MIDX_W-1:0]      map_dmem, map_pmem;
  logic [NUM_MEMBERS-1:0] map_dmask, map_pmask, need_mask, busy_all;

  parity_array_map #(.NUM_MEMBERS(NUM_MEMBERS), .LBA_W(LBA_W)) u_map (
    .lba_i       (req_lba_i),
    .stripe_o    (map_stripe),
    .data_mem_o  (map_dmem),
    .par_mem_o   (map_pmem),
    .data_mask_o (map_dmask),
    .par_mask_o  (map_pmask)
  );

  logic [NUM_ENG-1:0]            e_idle, e_done, e_start, e_grant, e_we, e_ackwr;
  logic [NUM_MEMBERS-1:0]        e_own   [NUM_ENG];
  logic [NUM_MEMBERS-1:0]        e_req   [NUM_ENG];
  logic [LBA_W-1:0]              e_addr  [NUM_ENG];
  logic [LBA_W-1:0]              e_acklba[NUM_ENG];
  logic [DATA_W-1:0]             e_rdata [NUM_ENG];
  logic [NUM_MEMBERS*DATA_W-1:0] e_wdata [NUM_ENG];

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    parity_array_engine #(
      .NUM_MEMBERS(NUM_MEMBERS), .DATA_W(DATA_W), .LBA_W(LBA_W)
    ) u_eng (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (e_start[e]),
      .write_i     (req_write_i),
      .lba_i       (req_lba_i),
      .wdata_i     (req_wdata_i),
      .stripe_i    (map_stripe),
      .data_mem_i  (map_dmem),
      .par_mem_i   (map_pmem),
      .data_mask_i (map_dmask),
      .par_mask_i  (map_pmask),
      .idle_o      (e_idle[e]),
      .own_o       (e_own[e]),
      .done_o      (e_done[e]),
      .grant_i     (e_grant[e]),
      .ack_write_o (e_ackwr[e]),
      .ack_lba_o   (e_acklba[e]),
      .ack_rdata_o (e_rdata[e]),
      .mem_req_o   (e_req[e]),
      .mem_we_o    (e_we[e]),
      .mem_addr_o  (e_addr[e]),
      .mem_wdata_o (e_wdata[e]),
      .mem_done_i  (mem_done_i),
      .mem_rdata_i (mem_rdata_i)
    );
  end

  // dispatch: lowest free engine, only if member sets are disjoint
  always_comb begin
    logic taken;
    need_mask = req_write_i ? (map_dmask | map_pmask) : map_dmask;
    busy_all  = '0;
    for (int e = 0; e < NUM_ENG; e++) busy_all |= e_own[e];
    req_ready_o = (|e_idle) && ((need_mask & busy_all) == '0);
    taken = 1'b0;
    for (int e = 0; e < NUM_ENG; e++) begin
      e_start[e] = req_valid_i && req_ready_o && e_idle[e] && !taken;
      taken      = taken | e_idle[e];
    end
  end

  // completion: lowest finished engine first
  always_comb begin
    logic taken;
    taken       = 1'b0;
    ack_valid_o = |e_done;
    ack_write_o = 1'b0;
    ack_lba_o   = '0;
    ack_rdata_o = '0;
    for (int e = 0; e < NUM_ENG; e++) begin
      e_grant[e] = e_done[e] && !taken;
      taken      = taken | e_done[e];
      if (e_grant[e]) begin
        ack_write_o = e_ackwr[e];
        ack_lba_o   = e_acklba[e];
        ack_rdata_o = e_rdata[e];
      end
    end
  end

  // member side: ownership is disjoint, so an OR merge is exact
  always_comb begin
    mem_req_o   = '0;
    mem_we_o    = '0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    for (int e = 0; e < NUM_ENG; e++) begin
      mem_req_o |= e_req[e];
      mem_we_o  |= e_req[e] & {NUM_MEMBERS{e_we[e]}};
      for (int m = 0; m < NUM_MEMBERS; m++) begin
        if (e_own[e][m]) begin
          mem_addr_o[m*LBA_W +: LBA_W]   |= e_addr[e];
          mem_wdata_o[m*DATA_W +: DATA_W] |= e_wdata[e][m*DATA_W +: DATA_W];
        end
      end
    end
  end

  // tracks open member operations for the R8 property
  logic [NUM_MEMBERS-1:0] outst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else         outst_q <= (outst_q | mem_req_o) & ~mem_done_i;
  end

  p_one_outstanding_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o & outst_q) == '0);

  p_map_distinct_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> (map_dmem != map_pmem));

  p_one_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(e_start));

  for (genvar m = 0; m < NUM_MEMBERS; m++) begin : g_own_chk
    logic [NUM_ENG-1:0] owners;
    always_comb
      for (int e = 0; e < NUM_ENG; e++) owners[e] = e_own[e][m];
    // R7: no member shared between in-flight requests
    p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owners));
  end
endmodule

// File: tb/parity_array_ctrl_tb.sv
module parity_array_ctrl_tb;
  localparam int NM = 5;
  localparam int DW = 16;
  localparam int LW = 6;
  localparam int NB = 64;
  localparam int NS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [LW-1:0] req_lba = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, ack_valid, ack_write;
  logic [LW-1:0] ack_lba;
  logic [DW-1:0] ack_rdata;
  logic [NM-1:0] mem_req, mem_we, mem_done;
  logic [NM*LW-1:0] mem_addr;
  logic [NM*DW-1:0] mem_wdata, mem_rdata;

  parity_array_ctrl #(.NUM_MEMBERS(NM), .DATA_W(DW), .LBA_W(LW), .NUM_ENG(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_lba_i(req_lba), .req_wdata_i(req_wdata),
    .ack_valid_o(ack_valid), .ack_write_o(ack_write), .ack_lba_o(ack_lba),
    .ack_rdata_o(ack_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_done_i(mem_done), .mem_rdata_i(mem_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int par_of(int s);
    return 4 - (s % 5);
  endfunction
  function automatic int dmem_of(int n);
    int p, sl;
    p  = par_of(n / 4);
    sl = n % 4;
    return (sl < p) ? sl : sl + 1;
  endfunction

  // reference state
  logic [DW-1:0] mdata [NM][NS];
  logic [DW-1:0] shadow [NB];
  logic [DW-1:0] exp_rd [NB];
  bit  exp_pend [NB];
  bit  exp_wr   [NB];
  int  rd_cnt [NM];
  int  wr_cnt [NM];
  int  rd_done_total = 0, rd_at_accept = 0;
  bit  single_mode = 1'b0;

  // member models
  bit  m_busy [NM];
  int  m_cnt  [NM];
  bit  m_we   [NM];
  int  m_addr [NM];
  logic [DW-1:0] m_wd [NM];
  int  op_seq = 0;

  initial begin
    for (int m = 0; m < NM; m++) begin
      for (int s = 0; s < NS; s++) mdata[m][s] = '0;
      m_busy[m] = 0; rd_cnt[m] = 0; wr_cnt[m] = 0;
    end
    for (int n = 0; n < NB; n++) begin
      shadow[n] = '0; exp_pend[n] = 0; exp_wr[n] = 0; exp_rd[n] = '0;
    end
    mem_done  = '0;
    mem_rdata = '0;
  end

  task automatic check_stripe(int s, string tag);
    logic [DW-1:0] x;
    int p;
    p = par_of(s);
    x = '0;
    for (int m = 0; m < NM; m++) if (m != p) x ^= mdata[m][s];
    chk(mdata[p][s] == x, tag, "stripe parity", int'(mdata[p][s]), int'(x));
  endtask

  // per-cycle reference: member models, protocol and completion checks
  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < NM; m++) begin
        mem_done[m] = 1'b0;
        if (m_busy[m]) begin
          m_cnt[m]--;
          if (m_cnt[m] == 0) begin
            m_busy[m]   = 0;
            mem_done[m] = 1'b1;
            if (m_we[m]) mdata[m][m_addr[m]] = m_wd[m];
            else begin
              mem_rdata[m*DW +: DW] = mdata[m][m_addr[m]];
              rd_done_total++;
            end
          end
        end
        if (mem_req[m]) begin
          if (m_busy[m]) chk(0, "R8", "op while busy on member", m, -1);
          if (mem_we[m] && single_mode)
            chk(rd_done_total - rd_at_accept >= 2, "R4", "write before both reads",
                rd_done_total - rd_at_accept, 2);
          if (mem_we[m]) wr_cnt[m]++; else rd_cnt[m]++;
          m_busy[m] = 1;
          op_seq++;
          m_cnt[m]  = 1 + ((m + op_seq) % 4);
          m_we[m]   = mem_we[m];
          m_addr[m] = int'(mem_addr[m*LW +: 4]);
          m_wd[m]   = mem_wdata[m*DW +: DW];
        end
      end
      if (ack_valid) begin
        int n;
        n = int'(ack_lba);
        chk(exp_pend[n], "R6", "ack without request, lba", n, -1);
        chk(ack_write == exp_wr[n], "R6", "ack type", int'(ack_write), int'(exp_wr[n]));
        if (exp_pend[n] && !exp_wr[n])
          chk(ack_rdata == exp_rd[n], "R3", "read data", int'(ack_rdata), int'(exp_rd[n]));
        if (exp_pend[n] && exp_wr[n]) begin
          check_stripe(n / 4, "R5");
          chk(mdata[dmem_of(n)][n/4] == shadow[n], "R6", "data on member",
              int'(mdata[dmem_of(n)][n/4]), int'(shadow[n]));
        end
        exp_pend[n] = 0;
      end
    end
  end

  // chk_rdy: -1 none, 0 expect stall, 1 expect accept, on first presentation
  task automatic send(bit wr, int n, logic [DW-1:0] d, int chk_rdy, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_lba = LW'(n); req_wdata = d;
    #1;
    if (chk_rdy >= 0)
      chk(req_ready == chk_rdy[0], tag, "ready with request in flight",
          int'(req_ready), chk_rdy);
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    exp_pend[n] = 1; exp_wr[n] = wr;
    if (wr) shadow[n] = d;
    exp_rd[n] = shadow[n];
    rd_at_accept = rd_done_total;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    bit any;
    do begin
      @(negedge clk); #2;
      any = 0;
      for (int n = 0; n < NB; n++) any |= exp_pend[n];
    end while (any);
  endtask

  task automatic single_op(bit wr, int n, logic [DW-1:0] d);
    int r0 [NM];
    int w0 [NM];
    int p, dm;
    for (int m = 0; m < NM; m++) begin r0[m] = rd_cnt[m]; w0[m] = wr_cnt[m]; end
    single_mode = 1'b1;
    send(wr, n, d, -1, "R6");
    wait_idle();
    single_mode = 1'b0;
    p  = par_of(n / 4);
    dm = dmem_of(n);
    for (int m = 0; m < NM; m++) begin
      if (wr) begin
        chk(rd_cnt[m] - r0[m] == ((m == dm || m == p) ? 1 : 0), "R1",
            "reads per member on write", rd_cnt[m] - r0[m], (m == dm || m == p) ? 1 : 0);
        chk(wr_cnt[m] - w0[m] == ((m == dm || m == p) ? 1 : 0), "R4",
            "writes per member on write", wr_cnt[m] - w0[m], (m == dm || m == p) ? 1 : 0);
      end else begin
        chk(rd_cnt[m] - r0[m] == ((m == dm) ? 1 : 0), "R2",
            "reads per member on read", rd_cnt[m] - r0[m], (m == dm) ? 1 : 0);
        chk(wr_cnt[m] - w0[m] == 0, "R3", "writes on read", wr_cnt[m] - w0[m], 0);
      end
    end
  endtask

  initial begin
    logic [31:0] rng;
    rng = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(req_ready == 1'b1, "R9", "ready in reset", int'(req_ready), 1);
    chk(mem_req == '0, "R9", "member ops in reset", int'(mem_req), 0);
    chk(ack_valid == 1'b0, "R9", "ack in reset", int'(ack_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == '0 && !ack_valid, "R9", "idle after reset", int'(mem_req), 0);

    // R1/R2/R4/R5: writes across all parity rotations, then reads
    for (int n = 0; n < 24; n++) single_op(1'b1, n, DW'(16'h1000 + n * 16'h0137));
    foreach (shadow[n]) if (n < 24) single_op(1'b0, n, '0);
    single_op(1'b1, 7, 16'hBEEF);
    single_op(1'b0, 7, '0);
    single_op(1'b1, 16, 16'h5A5A);
    single_op(1'b0, 16, '0);
    for (int s = 0; s < 6; s++) check_stripe(s, "R5");

    // R7: disjoint sets overlap, shared parity stalls
    send(1'b1, 0, 16'hA0A0, -1, "R7");
    send(1'b1, 5, 16'hA5A5, 1, "R7");
    wait_idle();
    send(1'b1, 0, 16'hC0C0, -1, "R7");
    send(1'b1, 1, 16'hC1C1, 0, "R7");
    chk(exp_pend[0] == 0, "R7", "second accepted before first done", int'(exp_pend[0]), 0);
    wait_idle();
    send(1'b0, 2, '0, -1, "R7");
    send(1'b0, 3, '0, 1, "R7");
    wait_idle();

    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      rng = rng * 32'd1103515245 + 32'd12345;
      send(rng[20] | rng[21], int'(rng[29:24]), rng[15:0], -1, "R6");
    end
    wait_idle();
    for (int s = 0; s < NS; s++) check_stripe(s, "R5");
    for (int n = 0; n < NB; n++)
      chk(mdata[dmem_of(n)][n/4] == shadow[n], "R2", "final block content",
          int'(mdata[dmem_of(n)][n/4]), int'(shadow[n]));

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL R6 watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule